// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobe

This block takes a five-digit BCD conversion result from a measurement controller. It presents the digits one at a time on a shared 4-bit bus, and a one-hot select line marks which digit is on the bus. Each digit holds the bus for a fixed slot of `SLOT_CNT` counts. The scan runs from the most significant digit down to the least significant digit and then wraps around to the most significant digit again.

A result-valid pulse loads a new result and starts a strobed pass. In each of the five slots of that pass, an active-low capture strobe appears near the middle of the slot, so an external latch or a processor can take that digit. After the strobed pass the scan keeps running without strobes to refresh a display. If the result was flagged over-range, the display is blanked once the strobed pass ends. It stays blanked until the controller signals the start of the next deintegrate phase.

The clock `clk_i` is a timebase at twice the conversion clock. One count is two ticks, so the strobe is exactly half a count wide.

Top module: `bcd_scan_strobe`

## Requirements
- R1: Reset state: `digit_sel_o` = only bit `ND-1` set (the most significant digit), `bcd_o` = 0 and `strobe_no` = 1. The first slot after reset is `SLOT_CNT+1` counts long.
- R2: `digit_sel_o` is one-hot or zero. Each select stays high for `SLOT_CNT` counts (`2*SLOT_CNT` ticks). Selects step from bit `ND-1` down to bit 0 and then wrap to bit `ND-1`.
- R3: While select bit k is high, `bcd_o` equals `result_i[4k+3:4k]` as latched on the last result-valid pulse. Digit 0 is the least significant digit.
- R4: The first slot after a result-valid pulse, a deintegrate-start pulse or an auto-zero-start pulse lasts `SLOT_CNT+1` counts, and it always shows the most significant digit.
- R5: After a result-valid pulse, each of the next `ND` slots has exactly one strobe, low for one tick. It falls on the first tick of count `STROBE_AT`, counted from 0 within the slot.
- R6: Slots outside that strobed pass carry no strobe. This covers the continued scanning and any scan restarted by a deintegrate-start or auto-zero-start pulse.
- R7: If `over_range_i` was high with the result-valid pulse, then from the end of the strobed pass both `digit_sel_o` and `bcd_o` are 0. An auto-zero-start pulse restarts the slot timing but does not end this blanking.
- R8: A deintegrate-start pulse ends the blanking and restarts the scan at the most significant digit.
- R9: A result-valid pulse in the middle of a scan restarts the scan at the most significant digit and re-arms all `ND` strobes. It also replaces the over-range flag, so a pending blanking with the flag now low does not occur.
- R10: When pulses coincide, result-valid takes precedence over deintegrate-start, and deintegrate-start takes precedence over auto-zero-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase at twice the conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 4*ND | Packed BCD digits; digit 0 is the least significant |
| result_valid_i | input | 1 | One-tick pulse: load result and start a strobed pass |
| over_range_i | input | 1 | Over-range flag, sampled with result_valid_i |
| deint_start_i | input | 1 | One-tick pulse at the start of deintegrate |
| az_start_i | input | 1 | One-tick pulse at the start of auto-zero |
| digit_sel_o | output | ND | One-hot digit select |
| bcd_o | output | 4 | BCD code of the selected digit |
| strobe_no | output | 1 | Capture strobe, active low, one tick wide |

## Verification
The hardest situations to reach from the ports are those where control pulses land in an awkward place. One is an auto-zero restart that arrives while the display is already blanked. Another is a result-valid pulse that lands partway through a strobed pass that would otherwise blank. A third is pulses that coincide in the same tick. The bench runs a small configuration with six-count slots. It first lets an over-range pass run until blanking begins, then injects auto-zero alone, deintegrate and auto-zero together, or result-valid together with deintegrate. It also issues a fresh result several slots into a pass. Every tick is compared against an arithmetic position model that restarts at each pulse, covering select, bus and strobe.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  typedef enum logic [1:0] {
    RS_NONE   = 2'd0,
    RS_RESULT = 2'd1,
    RS_DEINT  = 2'd2,
    RS_AZ     = 2'd3
  } restart_e;
endpackage

// File: rtl/scan_restart_arb.sv
module scan_restart_arb
  import bcd_scan_pkg::*;
(
  input  logic     result_valid_i,
  input  logic     deint_start_i,
  input  logic     az_start_i,
  output logic     restart_o,
  output restart_e cause_o
);
  always_comb begin
    if (result_valid_i)     cause_o = RS_RESULT;
    else if (deint_start_i) cause_o = RS_DEINT;
    else if (az_start_i)    cause_o = RS_AZ;
    else                    cause_o = RS_NONE;
    restart_o = (cause_o != RS_NONE);
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_CNT = 200,
  parameter int CW       = $clog2(SLOT_CNT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          long_i,
  output logic          half_o,
  output logic [CW-1:0] cnt_o,
  output logic          slot_end_o
);
  localparam logic [CW-1:0] LastShort = CW'(SLOT_CNT - 1);
  localparam logic [CW-1:0] LastLong  = CW'(SLOT_CNT);

  logic          half_q;
  logic [CW-1:0] cnt_q;

  assign slot_end_o = half_q && (cnt_q == (long_i ? LastLong : LastShort));
  assign half_o     = half_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart_i) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (half_q) begin
      half_q <= 1'b0;
      cnt_q  <= slot_end_o ? '0 : cnt_q + 1'b1;
    end else begin
      half_q <= 1'b1;
    end
  end
endmodule

// File: rtl/digit_ring.sv
module digit_ring #(
  parameter int ND = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          slot_end_i,
  output logic [ND-1:0] sel_o,
  output logic          long_o,
  output logic          last_o
);
  localparam logic [ND-1:0] MsdHot = ND'(1) << (ND - 1);

  logic [ND-1:0] sel_q;
  logic          long_q;

  assign sel_o  = sel_q;
  assign long_o = long_q;
  assign last_o = sel_q[0] && slot_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= MsdHot;
      long_q <= 1'b1;
    end else if (restart_i) begin
      sel_q  <= MsdHot;
      long_q <= 1'b1;
    end else if (slot_end_i) begin
      sel_q  <= sel_q[0] ? MsdHot : (sel_q >> 1);
      long_q <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int SLOT_CNT  = 200,
  parameter int STROBE_AT = SLOT_CNT / 2 + 1,
  parameter int CW        = $clog2(SLOT_CNT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  restart_e      cause_i,
  input  logic          over_range_i,
  input  logic          last_i,
  input  logic          half_i,
  input  logic [CW-1:0] cnt_i,
  output logic          strobe_no,
  output logic          blank_o
);
  localparam logic [CW-1:0] StrobeCnt = CW'(STROBE_AT);

  logic armed_q, ovr_q, blank_q;

  assign strobe_no = !(armed_q && !half_i && (cnt_i == StrobeCnt));
  assign blank_o   = blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      unique case (cause_i)
        RS_RESULT: begin
          armed_q <= 1'b1;
          ovr_q   <= over_range_i;
          blank_q <= 1'b0;
        end
        RS_DEINT: begin
          armed_q <= 1'b0;
          blank_q <= 1'b0;
        end
        RS_AZ: armed_q <= 1'b0;
        default: begin
          if (armed_q && last_i) begin
            armed_q <= 1'b0;
            blank_q <= ovr_q;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
  parameter int ND = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [4*ND-1:0] result_i,
  input  logic [ND-1:0]   sel_i,
  input  logic            blank_i,
  output logic [ND-1:0]   digit_sel_o,
  output logic [3:0]      bcd_o
);
  logic [4*ND-1:0] held_q;
  logic [3:0]      masked [ND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (load_i) held_q <= result_i;
  end

  for (genvar k = 0; k < ND; k++) begin : g_mask
    assign masked[k] = held_q[4*k +: 4] & {4{sel_i[k]}};
  end

  always_comb begin
    logic [3:0] acc;
    acc = '0;
    for (int k = 0; k < ND; k++) acc |= masked[k];
    bcd_o       = blank_i ? 4'd0 : acc;
    digit_sel_o = blank_i ? '0 : sel_i;
  end
endmodule

// File: rtl/bcd_scan_strobe.sv
module bcd_scan_strobe
  import bcd_scan_pkg::*;
#(
  parameter int ND        = 5,
  parameter int SLOT_CNT  = 200,
  parameter int STROBE_AT = SLOT_CNT / 2 + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4*ND-1:0] result_i,
  input  logic            result_valid_i,
  input  logic            over_range_i,
  input  logic            deint_start_i,
  input  logic            az_start_i,
  output logic [ND-1:0]   digit_sel_o,
  output logic [3:0]      bcd_o,
  output logic            strobe_no
);
  localparam int CW = $clog2(SLOT_CNT + 2);

  restart_e      cause;
  logic          restart, half, slot_end, long_slot, last, blank;
  logic [CW-1:0] cnt;
  logic [ND-1:0] sel;

  scan_restart_arb u_arb (
    .result_valid_i(result_valid_i),
    .deint_start_i (deint_start_i),
    .az_start_i    (az_start_i),
    .restart_o     (restart),
    .cause_o       (cause)
  );

  slot_timer #(.SLOT_CNT(SLOT_CNT), .CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .long_i    (long_slot),
    .half_o    (half),
    .cnt_o     (cnt),
    .slot_end_o(slot_end)
  );

  digit_ring #(.ND(ND)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .slot_end_i(slot_end),
    .sel_o     (sel),
    .long_o    (long_slot),
    .last_o    (last)
  );

  strobe_ctrl #(.SLOT_CNT(SLOT_CNT), .STROBE_AT(STROBE_AT), .CW(CW)) u_stb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cause_i     (cause),
    .over_range_i(over_range_i),
    .last_i      (last),
    .half_i      (half),
    .cnt_i       (cnt),
    .strobe_no   (strobe_no),
    .blank_o     (blank)
  );

  digit_mux #(.ND(ND)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (result_valid_i),
    .result_i   (result_i),
    .sel_i      (sel),
    .blank_i    (blank),
    .digit_sel_o(digit_sel_o),
    .bcd_o      (bcd_o)
  );
endmodule

// File: rtl/bcd_scan_strobe_chk.sv
module bcd_scan_strobe_chk #(
  parameter int ND        = 5,
  parameter int SLOT_CNT  = 200,
  parameter int STROBE_AT = SLOT_CNT / 2 + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          result_valid_i,
  input logic          deint_start_i,
  input logic [ND-1:0] digit_sel_o,
  input logic [3:0]    bcd_o,
  input logic          strobe_no
);
  initial begin
    a_params_r5: assert (STROBE_AT >= 1 && STROBE_AT < SLOT_CNT && ND >= 2)
      else $error("bad strobe placement parameters");
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(digit_sel_o));

  p_strobe_one_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |=> strobe_no);

  p_strobe_needs_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> (digit_sel_o != '0));

  p_blank_bus_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_sel_o == '0) |-> (bcd_o == 4'd0));

  p_deint_unblank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deint_start_i && !result_valid_i) |=> digit_sel_o[ND-1]);

  p_result_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i |=> (digit_sel_o[ND-1] && strobe_no));
endmodule

bind bcd_scan_strobe bcd_scan_strobe_chk #(
  .ND(ND), .SLOT_CNT(SLOT_CNT), .STROBE_AT(STROBE_AT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .result_valid_i(result_valid_i),
  .deint_start_i (deint_start_i),
  .digit_sel_o   (digit_sel_o),
  .bcd_o         (bcd_o),
  .strobe_no     (strobe_no)
);

// File: tb/sim_bcd_scan_strobe.sv
`timescale 1ns/1ps
module sim_bcd_scan_strobe;
  localparam int ND    = 5;
  localparam int SLOT  = 6;
  localparam int STR   = 4;
  localparam int NEVER = 1000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4*ND-1:0] res = '0;
  logic            rv = 1'b0, ovr = 1'b0, dei = 1'b0, az = 1'b0;
  logic [ND-1:0]   dsel;
  logic [3:0]      bcd;
  logic            stb_n;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bcd_scan_strobe #(.ND(ND), .SLOT_CNT(SLOT), .STROBE_AT(STR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .result_i(res), .result_valid_i(rv),
    .over_range_i(ovr), .deint_start_i(dei), .az_start_i(az),
    .digit_sel_o(dsel), .bcd_o(bcd), .strobe_no(stb_n));

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  // Compare one tick at position n after a restart against the arithmetic model.
  task automatic check_tick(input int n, input bit armed, input int blank_from,
                            input logic [4*ND-1:0] digs, input string tag);
    int slot, rem, cnt, ph, idx;
    logic [ND-1:0] e_sel;
    logic [3:0] e_bcd;
    logic e_stb;
    bit blank;
    if (n < 2 * (SLOT + 1)) begin slot = 0; rem = n; end
    else begin
      slot = 1 + (n - 2 * (SLOT + 1)) / (2 * SLOT);
      rem  = (n - 2 * (SLOT + 1)) % (2 * SLOT);
    end
    cnt = rem / 2; ph = rem % 2;
    idx = ND - 1 - (slot % ND);
    blank = (slot >= blank_from);
    e_sel = blank ? '0 : (ND'(1) << idx);
    e_bcd = blank ? 4'd0 : digs[4*idx +: 4];
    e_stb = !(armed && slot < ND && cnt == STR && ph == 0);
    total++;
    if (dsel !== e_sel || bcd !== e_bcd || stb_n !== e_stb) begin
      bad++;
      $display("FAIL %s n=%0d: actual sel=%b bcd=%0d stb_n=%b expected sel=%b bcd=%0d stb_n=%b",
               tag, n, dsel, bcd, stb_n, e_sel, e_bcd, e_stb);
    end
  endtask

  task automatic run_window(input int ticks, input bit armed, input int blank_from,
                            input logic [4*ND-1:0] digs, input string tag);
    for (int n = 0; n < ticks; n++) begin
      check_tick(n, armed, blank_from, digs, tag);
      @(negedge clk);
    end
  endtask

  // Drive one-tick pulses; returns at the negedge where state position is 0.
  task automatic pulse(input bit p_rv, input bit p_ovr, input bit p_dei, input bit p_az,
                       input logic [4*ND-1:0] digs);
    res = digs; rv = p_rv; ovr = p_ovr; dei = p_dei; az = p_az;
    @(negedge clk);
    rv = 0; ovr = 0; dei = 0; az = 0;
  endtask

  function automatic logic [4*ND-1:0] pattern(input int p);
    logic [4*ND-1:0] v;
    for (int k = 0; k < ND; k++) v[4*k +: 4] = 4'((p + 3 * k) % 10);
    return v;
  endfunction

  localparam int PASS = 2 * (SLOT + 1) + 2 * SLOT * (ND - 1);

  initial begin
    logic [4*ND-1:0] a, b;
    @(negedge clk); @(negedge clk);
    // R1: reset values
    total++;
    if (dsel !== 5'b10000 || bcd !== 4'd0 || stb_n !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset: actual sel=%b bcd=%0d stb_n=%b expected 10000 0 1", dsel, bcd, stb_n);
    end
    rst_n = 1'b1;
    // R1 R2 R6: idle scan from reset, long first slot, no strobes
    run_window(PASS + 2 * SLOT * 3, 0, NEVER, '0, "R1");

    // R2 R3 R5 R6: strobed pass then continued scan, several patterns
    for (int p = 0; p < 10; p++) begin
      a = pattern(p);
      pulse(1, 0, 0, 0, a);
      run_window(PASS + 2 * SLOT * (ND + 1), 1, NEVER, a, "R5");
    end
    a = 20'h98765;
    pulse(1, 0, 0, 0, a);
    run_window(PASS + 2 * SLOT * 2, 1, NEVER, a, "R3");

    // R7: over-range blanks after the strobed pass
    a = 20'h19999;
    pulse(1, 1, 0, 0, a);
    run_window(PASS + 2 * SLOT * 4, 1, ND, a, "R7");
    // R7: auto-zero restart keeps blanking
    pulse(0, 0, 0, 1, a);
    run_window(PASS + 2 * SLOT * 2, 0, 0, a, "R7");
    // R8 R4: deintegrate start unblanks, long first slot, no strobes (R6)
    pulse(0, 0, 1, 0, a);
    run_window(PASS + 2 * SLOT * 2, 0, NEVER, a, "R8");
    // R4 R6: auto-zero restart when not blanked
    pulse(0, 0, 0, 1, a);
    run_window(PASS, 0, NEVER, a, "R4");

    // R9: mid-scan result restarts and re-arms; over-range flag replaced
    a = 20'h13579; b = 20'h02468;
    pulse(1, 1, 0, 0, a);
    run_window(2 * (SLOT + 1) + 2 * SLOT * 2 + 5, 1, ND, a, "R9");
    pulse(1, 0, 0, 0, b);
    run_window(PASS + 2 * SLOT * 3, 1, NEVER, b, "R9");

    // R10: result beats deintegrate in the same tick
    a = 20'h11111;
    pulse(1, 1, 1, 0, a);
    run_window(PASS + 2 * SLOT * 2, 1, ND, a, "R10");
    // R10: deintegrate beats auto-zero, so blanking ends
    pulse(0, 0, 1, 1, a);
    run_window(PASS, 0, NEVER, a, "R10");
    // R10: result beats auto-zero
    b = 20'h24680;
    pulse(1, 0, 0, 1, b);
    run_window(PASS, 1, NEVER, b, "R10");

    finish_run();
  end
endmodule